// File: doc/BRIEF.md
# Acknowledging Packet Frame Receiver

This block accepts a packet frame one byte at a time from a byte-serial bus front end. A byte is taken on each cycle where `rx_valid` is high. The block walks the frame's fields and learns from the header's flag bits which optional fields follow. It streams the payload bytes to downstream logic as they arrive. When the frame closes, it reports the checksum verdict together with any sender address and packet identifier that the frame carried.

A frame passes the address check when its recipient byte equals `my_id`. In bus-addressed frames, the receiver bus identifier must also equal `my_bus`. A frame that fails the address check produces no output. If the header asks for an immediate reply, the block presents one response byte for the upstream transmitter at the end of the frame: an acknowledge code when the checksum is good, a negative code when it is not. Frames whose length field is impossible are abandoned, and the parser returns to waiting for a new recipient byte.

Top module: `ackframe_rx`

## Requirements
- R1: The field order is recipient, header, length, then the optional fields, then the payload, then the checksum. Each payload byte appears on `pay_byte` with `pay_valid` high exactly once, in arrival order, one cycle after it was accepted.
- R2: Header bit 1 (0x02) marks the frame as carrying sender info. Without bit 0 that info is one sender-ID byte. With bit 0 (0x01) a 4-byte sender bus ID, most significant byte first, comes before the sender-ID byte. The values appear on `src_bus` and `src_id`, with `src_present` high, when `done` pulses. `src_bus` reads 0 when the frame has no sender bus ID.
- R3: Header bit 3 (0x08) marks a 2-byte packet identifier, most significant byte first, placed right after the sender info. It is reported on `pkt_id` with `pid_present` high when `done` pulses.
- R4: The length byte counts every byte from the recipient through the checksum. The payload size is the length minus the overhead. The overhead is 4, plus 4 when bit 0 is set, plus 1 (or 5 when bit 0 is set) when bit 1 is set, plus 2 when bit 3 is set.
- R5: The checksum is a CRC-8 with reflected polynomial 0x8C and initial value 0, taken over every byte before the checksum. `done_ok` tells whether the checksum byte matched.
- R6: When header bit 2 (0x04) is set on an addressed frame, `resp_valid` pulses together with `done`, one cycle after the checksum byte. `resp_byte` is then 6 on a good checksum and 21 on a bad one.
- R7: When header bit 2 is clear, an addressed frame still pulses `done`, but no response byte is produced.
- R8: A frame whose recipient byte differs from `my_id` produces no payload, no `done` and no response.
- R9: In bus-addressed frames, the 4-byte receiver bus ID follows the length byte, most significant byte first. A mismatch with `my_bus` in any byte silences the frame as in R8.
- R10: A length below the overhead of R4, or above `MAX_LEN` (default 64), abandons the frame with no output. The next accepted byte is taken as a new recipient byte. A length of exactly `MAX_LEN` is accepted.
- R11: After reset, every output is 0 and the parser waits for a recipient byte.
- R12: Cycles with `rx_valid` low leave the parse untouched, so gaps between bytes do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Byte strobe from the bus front end |
| rx_byte | input | 8 | Received byte |
| my_id | input | 8 | Local device identifier |
| my_bus | input | 32 | Local bus identifier |
| resp_valid | output | 1 | Response byte ready for the transmitter |
| resp_byte | output | 8 | Response code: 6 for good, 21 for bad |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| done | output | 1 | Addressed frame finished |
| done_ok | output | 1 | Checksum matched |
| src_present | output | 1 | Frame carried sender info |
| pid_present | output | 1 | Frame carried a packet identifier |
| src_bus | output | 32 | Sender bus identifier |
| src_id | output | 8 | Sender device identifier |
| pkt_id | output | 16 | Packet identifier |

## Verification
The properties assume that the front end delivers at most one byte per cycle and holds `my_id` and `my_bus` steady for the length of a frame. They also assume that every frame is sent in full once its length byte is accepted, so that payload and frame-end events come only from accepted bytes. The stimulus changes the configuration only at reset. It sends complete frames, except for frames with a rejected length, which it cuts right after the length byte. It leaves idle cycles between frames, and sometimes between bytes, without ever giving two bytes in one cycle.

// File: rtl/ackframe_rx.sv
module ackframe_rx #(
  parameter int         MAX_LEN  = 64,
  parameter logic [7:0] ACK_CODE = 8'd6,
  parameter logic [7:0] NAK_CODE = 8'd21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [7:0]  my_id,
  input  logic [31:0] my_bus,
  output logic        resp_valid,
  output logic [7:0]  resp_byte,
  output logic        pay_valid,
  output logic [7:0]  pay_byte,
  output logic        done,
  output logic        done_ok,
  output logic        src_present,
  output logic        pid_present,
  output logic [31:0] src_bus,
  output logic [7:0]  src_id,
  output logic [15:0] pkt_id
);

  localparam logic [7:0] MAX8 = 8'(MAX_LEN);
  localparam logic [3:0] S_ID = 4'd0, S_HDR = 4'd1, S_LEN = 4'd2, S_RXBUS = 4'd3,
                         S_SBUS = 4'd4, S_SID = 4'd5, S_PID = 4'd6, S_DATA = 4'd7,
                         S_CRC = 4'd8;

  logic [3:0]  st, st_after;
  logic [3:0]  hdr;
  logic [7:0]  crc, crc_nx, clen, clen_nx, cl_eff, left, left_nx, minlen;
  logic        miss;
  logic [31:0] sbus_acc;
  logic [7:0]  sid_acc;
  logic [15:0] pid_acc;

  wire bus_m = hdr[0];
  wire src_m = hdr[1];
  wire ack_m = hdr[2];
  wire pid_m = hdr[3];

  assign minlen  = 8'd4 + (bus_m ? 8'd4 : 8'd0) + (src_m ? (bus_m ? 8'd5 : 8'd1) : 8'd0)
                 + (pid_m ? 8'd2 : 8'd0);
  assign clen_nx = rx_byte - minlen;
  assign cl_eff  = (st == S_LEN) ? clen_nx : clen;
  wire   len_bad = (rx_byte < minlen) || (rx_byte > MAX8);
  wire   crc_hit = (crc == rx_byte);

  always_comb begin
    crc_nx = ((st == S_ID) ? 8'h00 : crc) ^ rx_byte;
    for (int i = 0; i < 8; i++)
      crc_nx = crc_nx[0] ? ((crc_nx >> 1) ^ 8'h8C) : (crc_nx >> 1);
  end

  always_comb begin
    if (st == S_LEN && bus_m)                 st_after = S_RXBUS;
    else if (st < S_SBUS && src_m && bus_m)   st_after = S_SBUS;
    else if (st < S_SID && src_m)             st_after = S_SID;
    else if (st < S_PID && pid_m)             st_after = S_PID;
    else if (st < S_DATA && cl_eff != 8'd0)   st_after = S_DATA;
    else                                      st_after = S_CRC;
  end

  always_comb begin
    case (st_after)
      S_RXBUS, S_SBUS: left_nx = 8'd3;
      S_PID:           left_nx = 8'd1;
      S_DATA:          left_nx = cl_eff - 8'd1;
      default:         left_nx = 8'd0;
    endcase
  end

  wire field_end = (left == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ID;
      hdr <= '0;
      crc <= '0;
      clen <= '0;
      left <= '0;
      miss <= 1'b0;
      sbus_acc <= '0;
      sid_acc <= '0;
      pid_acc <= '0;
      resp_valid <= 1'b0;
      resp_byte <= '0;
      pay_valid <= 1'b0;
      pay_byte <= '0;
      done <= 1'b0;
      done_ok <= 1'b0;
      src_present <= 1'b0;
      pid_present <= 1'b0;
      src_bus <= '0;
      src_id <= '0;
      pkt_id <= '0;
    end else begin
      pay_valid <= 1'b0;
      done <= 1'b0;
      resp_valid <= 1'b0;
      if (rx_valid) begin
        if (st != S_CRC) crc <= crc_nx;
        case (st)
          S_ID: begin
            miss <= (rx_byte != my_id);
            sbus_acc <= '0;
            sid_acc <= '0;
            pid_acc <= '0;
            st <= S_HDR;
          end
          S_HDR: begin
            hdr <= rx_byte[3:0];
            st <= S_LEN;
          end
          S_LEN: begin
            if (len_bad) st <= S_ID;
            else begin
              clen <= clen_nx;
              left <= left_nx;
              st <= st_after;
            end
          end
          S_RXBUS, S_SBUS, S_PID, S_DATA: begin
            if (st == S_RXBUS && rx_byte != my_bus[{left[1:0], 3'b000} +: 8]) miss <= 1'b1;
            if (st == S_SBUS) sbus_acc <= {sbus_acc[23:0], rx_byte};
            if (st == S_PID) pid_acc <= {pid_acc[7:0], rx_byte};
            if (st == S_DATA && !miss) begin
              pay_valid <= 1'b1;
              pay_byte <= rx_byte;
            end
            if (field_end) begin
              st <= st_after;
              left <= left_nx;
            end else begin
              left <= left - 8'd1;
            end
          end
          S_SID: begin
            sid_acc <= rx_byte;
            st <= st_after;
            left <= left_nx;
          end
          default: begin
            if (!miss) begin
              done <= 1'b1;
              done_ok <= crc_hit;
              resp_valid <= ack_m;
              resp_byte <= crc_hit ? ACK_CODE : NAK_CODE;
              src_present <= src_m;
              pid_present <= pid_m;
              src_bus <= sbus_acc;
              src_id <= sid_acc;
              pkt_id <= pid_acc;
            end
            st <= S_ID;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ackframe_rx_chk.sv
module ackframe_rx_chk #(
  parameter logic [7:0] ACK_CODE = 8'd6,
  parameter logic [7:0] NAK_CODE = 8'd21
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       resp_valid,
  input logic [7:0] resp_byte,
  input logic       pay_valid,
  input logic       done,
  input logic       done_ok
);

  // R6
  resp_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> done);

  // R6
  resp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_byte == ACK_CODE || resp_byte == NAK_CODE));

  // R5
  resp_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((resp_byte == ACK_CODE) == done_ok));

  // R1
  pay_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> $past(rx_valid));

  // R12
  done_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rx_valid));

  // R1
  pay_not_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pay_valid && done));

endmodule

bind ackframe_rx ackframe_rx_chk #(.ACK_CODE(ACK_CODE), .NAK_CODE(NAK_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .resp_valid(resp_valid),
  .resp_byte(resp_byte), .pay_valid(pay_valid), .done(done), .done_ok(done_ok)
);

// File: tb/ackframe_rx_tb.sv
`timescale 1ns/1ps
module ackframe_rx_tb;
  typedef logic [7:0] u8;
  localparam u8           MY_ID  = 8'h2C;
  localparam logic [31:0] MY_BUS = 32'h0000_0002;

  logic clk = 0, rst_n = 0, rx_valid = 0;
  u8 rx_byte = 0;
  logic resp_valid, pay_valid, done, done_ok, src_present, pid_present;
  logic [7:0] resp_byte, pay_byte, src_id;
  logic [31:0] src_bus;
  logic [15:0] pkt_id;

  ackframe_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .my_id(MY_ID), .my_bus(MY_BUS), .resp_valid(resp_valid), .resp_byte(resp_byte),
    .pay_valid(pay_valid), .pay_byte(pay_byte), .done(done), .done_ok(done_ok),
    .src_present(src_present), .pid_present(pid_present), .src_bus(src_bus),
    .src_id(src_id), .pkt_id(pkt_id)
  );

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0, done_seen = 0;
  bit mon_on = 0, finished = 0;
  u8 fr[$];
  u8 e_pay[$];
  bit e_ok[$];
  int e_resp[$];
  logic [31:0] e_sbus[$];
  u8 e_sid[$];
  logic [15:0] e_pid[$];
  bit e_src[$];
  bit e_pidp[$];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic u8 crc_of(int n);
    u8 c = 0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        bit fb = c[0] ^ fr[k][b];
        c = c >> 1;
        if (fb) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  task automatic build(u8 id, u8 hdr, logic [31:0] rbus, logic [31:0] sbus, u8 sid,
                       logic [15:0] pid, int nc, u8 seed, bit corrupt);
    u8 c;
    fr.delete();
    fr.push_back(id); fr.push_back(hdr); fr.push_back(8'd0);
    if (hdr[0]) for (int k = 3; k >= 0; k--) fr.push_back(rbus[8*k +: 8]);
    if (hdr[1]) begin
      if (hdr[0]) for (int k = 3; k >= 0; k--) fr.push_back(sbus[8*k +: 8]);
      fr.push_back(sid);
    end
    if (hdr[3]) begin fr.push_back(pid[15:8]); fr.push_back(pid[7:0]); end
    for (int k = 0; k < nc; k++) fr.push_back(u8'(seed + k * 7));
    fr[2] = u8'(fr.size() + 1);
    c = crc_of(fr.size());
    fr.push_back(corrupt ? (c ^ 8'h5A) : c);
  endtask

  task automatic model(output int nframes);
    int len, mn, p;
    u8 h;
    logic [31:0] rb, sb;
    u8 sid;
    logic [15:0] pid;
    bit ok;
    nframes = 0;
    if (fr[0] != MY_ID) return;
    h = fr[1]; len = fr[2];
    mn = 4 + (h[0] ? 4 : 0) + (h[1] ? (h[0] ? 5 : 1) : 0) + (h[3] ? 2 : 0);
    if (len < mn || len > 64) return;
    p = 3; sb = 0; sid = 0; pid = 0;
    if (h[0]) begin
      rb = {fr[3], fr[4], fr[5], fr[6]}; p = 7;
      if (rb != MY_BUS) return;
    end
    if (h[1]) begin
      if (h[0]) begin sb = {fr[p], fr[p+1], fr[p+2], fr[p+3]}; p += 4; end
      sid = fr[p]; p++;
    end
    if (h[3]) begin pid = {fr[p], fr[p+1]}; p += 2; end
    for (; p < len - 1; p++) e_pay.push_back(fr[p]);
    ok = (crc_of(len - 1) == fr[len-1]);
    e_ok.push_back(ok);
    e_resp.push_back(h[2] ? (ok ? 6 : 21) : -1);
    e_sbus.push_back(sb); e_sid.push_back(sid); e_pid.push_back(pid);
    e_src.push_back(h[1]); e_pidp.push_back(h[3]);
    nframes = 1;
  endtask

  task automatic send(bit gaps, string tag);
    int nf, d0;
    d0 = done_seen;
    model(nf);
    for (int k = 0; k < fr.size(); k++) begin
      @(negedge clk); rx_valid = 1; rx_byte = fr[k];
      if (gaps && (k % 2 == 1)) begin @(negedge clk); rx_valid = 0; rx_byte = 8'hFF; end
    end
    @(negedge clk); rx_valid = 0; rx_byte = 0;
    repeat (3) @(negedge clk);
    chk({tag, " frame-end count"}, done_seen - d0, nf);
    chk({tag, " pending expectations"}, e_pay.size() + e_ok.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (pay_valid) begin
        if (e_pay.size() == 0) chk("R8 unexpected payload", 1, 0);
        else chk("R1 payload byte", pay_byte, e_pay.pop_front());
      end
      if (done) begin
        done_seen++;
        if (e_ok.size() == 0) chk("R8 unexpected frame end", 1, 0);
        else begin
          int r; bit s, pp; logic [31:0] sb; u8 sid; logic [15:0] pid;
          r = e_resp.pop_front(); s = e_src.pop_front(); pp = e_pidp.pop_front();
          sb = e_sbus.pop_front(); sid = e_sid.pop_front(); pid = e_pid.pop_front();
          chk("R5 checksum verdict", done_ok, e_ok.pop_front());
          chk("R6/R7 response present", resp_valid, r >= 0);
          if (r >= 0) chk("R6 response code", resp_byte, r);
          chk("R2 sender flag", src_present, s);
          if (s) begin
            chk("R2 sender bus", src_bus, sb);
            chk("R2 sender id", src_id, sid);
          end
          chk("R3 packet id flag", pid_present, pp);
          if (pp) chk("R3 packet id", pkt_id, pid);
        end
      end else if (resp_valid) chk("R7 stray response", 1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk("R11 reset outputs", {resp_valid, pay_valid, done, done_ok, src_present, pid_present}, 0);
    chk("R11 reset data", {resp_byte, pay_byte, src_id, src_bus, pkt_id}, 0);
    mon_on = 1;

    build(MY_ID, 8'h0E, 0, 0, 8'h11, 16'h0063, 3, 8'h40, 0); send(0, "R1");
    build(MY_ID, 8'h0E, 0, 0, 8'h11, 16'h0063, 3, 8'h40, 1); send(0, "R5");
    build(MY_ID, 8'h0F, MY_BUS, 32'h0000_0001, 8'h00, 16'd99, 1, 8'd64, 0);
    chk("R4 length field of full bus frame", fr[2], 16);
    send(0, "R4");
    build(MY_ID, 8'h0F, MY_BUS, 32'h0A0B_0C0D, 8'h07, 16'd99, 0, 8'd0, 0); send(0, "R4");
    build(MY_ID, 8'h0F, 32'h0000_0003, 32'h1, 8'h00, 16'd5, 2, 8'h20, 0); send(0, "R9");
    build(MY_ID, 8'h0F, 32'h0100_0002, 32'h1, 8'h00, 16'd5, 2, 8'h20, 0); send(0, "R9");
    build(MY_ID + 8'd1, 8'h06, 0, 0, 8'h03, 0, 4, 8'h30, 0); send(0, "R8");
    build(MY_ID, 8'h00, 0, 0, 0, 0, 2, 8'h55, 0); send(0, "R7");
    fr = '{MY_ID, 8'h0F, 8'd10}; send(0, "R10");
    build(MY_ID, 8'h06, 0, 0, 8'h42, 0, 2, 8'h01, 0); send(0, "R10");
    fr = '{MY_ID, 8'h04, 8'd65}; send(0, "R10");
    build(MY_ID, 8'h04, 0, 0, 0, 0, 60, 8'h03, 0); send(0, "R10");
    build(MY_ID, 8'h0C, 0, 0, 0, 16'hBEEF, 5, 8'h90, 0); send(1, "R12");
    build(MY_ID, 8'h0D, MY_BUS, 0, 0, 16'h1234, 2, 8'hE0, 1); send(1, "R5");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule